// File: doc/BRIEF.md
# Key-Protected Memory Scrub Controller

This block clears every word of an on-chip single-port memory bank on a software command. Software sees two 32-bit registers on a simple register port with an address, a write enable, write data and combinational read data. The control register holds a start bit and a busy flag. The unlock register must be written with a two-value key before the start bit will take a write.

Once a start is accepted, a sweep engine writes zero to one word per clock. It walks from address 0 up to the last word. The start bit then clears itself. The unlock is used up by that one start, so the next erase needs the key again.

While the sweep runs, the normal memory access port is fenced off. Its writes are dropped and its reads return zero.

The key tracker is a three-state machine:

- `KEY_LOCKED` moves to `KEY_HALF` on a write of 0xCA.
- `KEY_HALF` moves to `KEY_ARMED` on a write of 0x53. Any other write returns it to `KEY_LOCKED`.
- `KEY_ARMED` returns to `KEY_LOCKED` on any unlock-register write or on an accepted start.

The sweep engine has two states:

- `SW_IDLE` moves to `SW_RUN` on an accepted start.
- `SW_RUN` returns to `SW_IDLE` after writing the last address.

Top module: `mem_scrub_ctrl`

## Requirements
- R1: After reset, the control register (register address 0) reads 0, and the key tracker is locked.
- R2: Bits 31:2 of the control register read 0 and ignore writes. The unlock register (register address 1) and unused register addresses read 0.
- R3: While locked, writing 1 to control bit 0 has no effect: the register keeps reading 0 and no sweep starts.
- R4: Writing 0xCA and then 0x53 to register address 1 arms the tracker. A following write with bit 0 set to register address 0 starts a sweep.
- R5: A wrong value or a wrong order in the key writes relocks the tracker. Examples are 0xCA, 0x11, 0x53 and 0xCA, 0xCA, 0x53. A start write after such a sequence has no effect.
- R6: An accepted start consumes the unlock. A second start written after the sweep, without a new key, has no effect.
- R7: Busy (bit 1) rises in the cycle after the start is accepted. It stays 1 for exactly DEPTH cycles, with one word zeroed per cycle in ascending address order.
- R8: Bit 0 reads 1 for exactly as long as busy does and is cleared by hardware at the end of the sweep. A software write of 0 to it during the sweep does not clear it.
- R9: After a sweep, every memory word reads 0.
- R10: Writes of 1 to bit 0 while busy neither restart nor lengthen the sweep.
- R11: While busy, the memory access port returns 0 on reads, and its writes are discarded.
- R12: While idle, the memory access port writes on the clock edge and reads combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 unlock |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_addr | input | AW | Memory access address |
| mem_we | input | 1 | Memory access write enable |
| mem_wdata | input | DW | Memory access write data |
| mem_rdata | output | DW | Memory access read data (0 while busy) |

## Verification
The bench builds the block with DEPTH=8 and DW=16. The short bank lets the whole sweep be counted cycle by cycle. It also lets every word be preloaded with a nonzero value and read back afterwards.

With eight words, the sweep passes address 0 in its first cycle. A fenced write to address 0 later in the sweep would therefore survive if the fence leaked. The sweep also lasts long enough for a software clear, a repeated start and a blocked read to fall inside one run.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
    typedef enum logic [1:0] {
        KEY_LOCKED = 2'd0,
        KEY_HALF   = 2'd1,
        KEY_ARMED  = 2'd2
    } key_state_t;

    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sweep_state_t;

    localparam logic [1:0]  REG_CTRL   = 2'd0;
    localparam logic [1:0]  REG_UNLOCK = 2'd1;
    localparam logic [31:0] KEY_FIRST  = 32'h0000_00CA;
    localparam logic [31:0] KEY_SECOND = 32'h0000_0053;
endpackage

// File: rtl/scrub_key_lock.sv
module scrub_key_lock
    import scrub_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    input  logic        consume,
    output logic        armed
);
    key_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= KEY_LOCKED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            KEY_LOCKED: if (key_wr && key_data == KEY_FIRST) state_nx = KEY_HALF;
            KEY_HALF:   if (key_wr) state_nx = (key_data == KEY_SECOND) ? KEY_ARMED : KEY_LOCKED;
            KEY_ARMED:  if (key_wr || consume) state_nx = KEY_LOCKED;
            default:    state_nx = KEY_LOCKED;
        endcase
    end

    always_comb armed = (state == KEY_ARMED);

    // R4: the armed state is only entered from the half-keyed state
    a_r4_arm_path: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KEY_ARMED && $past(state) != KEY_ARMED) |-> $past(state) == KEY_HALF);
    // R6: a consumed unlock leaves the tracker locked
    a_r6_consume: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> state == KEY_LOCKED);
    // R5: a wrong second key value relocks
    a_r5_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KEY_HALF && key_wr && key_data != KEY_SECOND) |=> state == KEY_LOCKED);
endmodule

// File: rtl/scrub_sweep.sv
module scrub_sweep
    import scrub_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic          busy,
    output logic          done,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    sweep_state_t  state, state_nx;
    logic [AW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SW_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            SW_IDLE: if (go) begin
                state_nx = SW_RUN;
                cnt_nx   = '0;
            end
            SW_RUN: begin
                if (cnt == LAST) state_nx = SW_IDLE;
                else             cnt_nx   = cnt + 1'b1;
            end
            default: state_nx = SW_IDLE;
        endcase
    end

    always_comb begin
        busy    = (state == SW_RUN);
        wr_en   = (state == SW_RUN);
        wr_addr = cnt;
        done    = (state == SW_RUN) && (cnt == LAST);
    end

    // R7: the sweep starts at address 0
    a_r7_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wr_addr == '0);
    // R7: one word per cycle, ascending
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> wr_addr == AW'($past(wr_addr) + 1'b1));
    // R7: the sweep ends right after the last word
    a_r7_end: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_addr == LAST) |=> !busy);
endmodule

// File: rtl/scrub_ram.sv
module scrub_ram #(
    parameter int DEPTH = 256,
    parameter int DW    = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mem_scrub_ctrl.sv
module mem_scrub_ctrl
    import scrub_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int DW    = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic          reg_we,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic [AW-1:0] mem_addr,
    input  logic          mem_we,
    input  logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] mem_rdata
);
    logic          ctrl_wr, key_wr, start_req, accept;
    logic          armed, busy, done, start_q;
    logic          sw_we;
    logic [AW-1:0] sw_addr;
    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic [DW-1:0] ram_wdata, ram_rdata;

    always_comb begin
        ctrl_wr   = reg_we && (reg_addr == REG_CTRL);
        key_wr    = reg_we && (reg_addr == REG_UNLOCK);
        start_req = ctrl_wr && reg_wdata[0];
        accept    = start_req && armed && !busy;
    end

    scrub_key_lock u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (reg_wdata),
        .consume  (accept),
        .armed    (armed)
    );

    scrub_sweep #(.DEPTH(DEPTH)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (accept),
        .busy    (busy),
        .done    (done),
        .wr_en   (sw_we),
        .wr_addr (sw_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      start_q <= 1'b0;
        else if (accept) start_q <= 1'b1;
        else if (done)   start_q <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_CTRL) reg_rdata[1:0] = {busy, start_q};
    end

    always_comb begin
        ram_we    = busy ? sw_we   : mem_we;
        ram_waddr = busy ? sw_addr : mem_addr;
        ram_wdata = busy ? '0      : mem_wdata;
        mem_rdata = busy ? '0      : ram_rdata;
    end

    scrub_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (mem_addr),
        .rdata (ram_rdata)
    );

    // R8: the start bit tracks the busy flag
    a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_q == busy);
    // R3: a start while locked leaves the engine idle
    a_r3_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !armed && !busy) |=> !busy);
    // R11: the access port is fenced during a sweep
    a_r11_fence: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_rdata == '0 && ram_wdata == '0));
    // R2: reserved bits read zero
    a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:2] == '0);
endmodule

// File: tb/mem_scrub_ctrl_test.sv
module mem_scrub_ctrl_test;
    localparam int DEPTH = 8;
    localparam int DW    = 16;
    localparam int AW    = 3;
    localparam int NV    = 22;

    // op: 0 reg write, 1 reg read check, 2 mem write, 3 mem read check
    localparam logic [69:0] VEC [NV] = '{
        {2'd1, 4'd0, 32'h0,          32'h0},        // R1 ctrl after reset
        {2'd1, 4'd1, 32'h0,          32'h0},        // R2 unlock reg reads 0
        {2'd2, 4'd3, 32'h1234,       32'h0},        // R12
        {2'd2, 4'd7, 32'hBEEF,       32'h0},        // R12
        {2'd3, 4'd3, 32'h0,          32'h1234},     // R12
        {2'd3, 4'd7, 32'h0,          32'hBEEF},     // R12
        {2'd0, 4'd0, 32'hFFFF_FFFC,  32'h0},        // R2 reserved write
        {2'd1, 4'd0, 32'h0,          32'h0},        // R2
        {2'd0, 4'd0, 32'h1,          32'h0},        // R3 locked start
        {2'd1, 4'd0, 32'h0,          32'h0},        // R3
        {2'd3, 4'd7, 32'h0,          32'hBEEF},     // R3 no erase
        {2'd0, 4'd1, 32'hCA,         32'h0},        // R5 CA,11,53
        {2'd0, 4'd1, 32'h11,         32'h0},
        {2'd0, 4'd1, 32'h53,         32'h0},
        {2'd0, 4'd0, 32'h1,          32'h0},
        {2'd1, 4'd0, 32'h0,          32'h0},        // R5
        {2'd0, 4'd1, 32'hCA,         32'h0},        // R5 CA,CA,53
        {2'd0, 4'd1, 32'hCA,         32'h0},
        {2'd0, 4'd1, 32'h53,         32'h0},
        {2'd0, 4'd0, 32'h1,          32'h0},
        {2'd1, 4'd0, 32'h0,          32'h0},        // R5
        {2'd3, 4'd3, 32'h0,          32'h1234}      // R5 no erase
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [AW-1:0] mem_addr = '0;
    logic          mem_we = 1'b0;
    logic [DW-1:0] mem_wdata = '0;
    logic [DW-1:0] mem_rdata;

    int nchk = 0;
    int nfail = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    mem_scrub_ctrl #(.DEPTH(DEPTH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic mem_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        mem_addr = a; mem_wdata = d; mem_we = 1'b1;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic reg_chk(input string tag, input logic [1:0] a, input logic [31:0] e);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, e);
    endtask

    task automatic mem_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] e);
        mem_addr = a;
        #1;
        check(tag, 32'(mem_rdata), 32'(e));
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  ad;
            logic [31:0] dt, ex;
            {op, ad, dt, ex} = VEC[i];
            unique case (op)
                2'd0: reg_wr(ad[1:0], dt);
                2'd1: reg_chk("R1/R2/R3/R5 reg", ad[1:0], ex);
                2'd2: mem_wr(ad[AW-1:0], dt[DW-1:0]);
                default: mem_chk("R3/R5/R12 mem", ad[AW-1:0], ex[DW-1:0]);
            endcase
        end

        // preload every word with a nonzero value
        for (int a = 0; a < DEPTH; a++) mem_wr(AW'(a), DW'(16'h5A00 + a));
        reg_chk("R2 unused address", 2'd3, 32'h0);

        // R4: unlock then start
        reg_wr(2'd1, 32'hCA);
        reg_wr(2'd1, 32'h53);
        reg_chk("R7 not busy before accept edge", 2'd0, 32'h0);
        reg_wr(2'd0, 32'h1);
        mem_addr = 3'd7;
        reg_addr = 2'd0;
        #1;
        check("R4 start accepted", reg_rdata, 32'h3);
        cnt = 0;
        while (reg_rdata[1] && cnt < 100) begin
            cnt++;
            check("R8 start bit with busy", reg_rdata, 32'h3);
            if (cnt == 1) check("R11 blocked read", 32'(mem_rdata), 32'h0);
            reg_we    = (cnt == 2) || (cnt == 3);
            reg_wdata = (cnt == 3) ? 32'h1 : 32'h0;   // R8 clear attempt, R10 restart attempt
            mem_we    = (cnt == 5);
            mem_addr  = (cnt == 5) ? 3'd0 : 3'd7;
            mem_wdata = 16'hABCD;
            @(negedge clk);
            reg_we = 1'b0; mem_we = 1'b0;
            #1;
        end
        check("R7/R10 busy cycles", 32'(cnt), 32'(DEPTH));
        reg_chk("R8 self-clear", 2'd0, 32'h0);
        for (int a = 0; a < DEPTH; a++) mem_chk("R9/R11 word zero", AW'(a), '0);

        // R6: unlock consumed
        mem_wr(3'd2, 16'h7777);
        reg_wr(2'd0, 32'h1);
        reg_chk("R6 start needs new key", 2'd0, 32'h0);
        mem_chk("R6 no erase", 3'd2, 16'h7777);

        // R4: a second keyed erase works
        reg_wr(2'd1, 32'hCA);
        reg_wr(2'd1, 32'h53);
        reg_wr(2'd0, 32'h1);
        reg_chk("R4 second start", 2'd0, 32'h3);
        repeat (DEPTH) @(negedge clk);
        reg_chk("R7 second sweep done", 2'd0, 32'h0);
        mem_chk("R9 second erase", 3'd2, '0);

        // R1: reset returns to zero state and locks
        reg_wr(2'd1, 32'hCA);
        reg_wr(2'd1, 32'h53);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        reg_wr(2'd0, 32'h1);
        reg_chk("R1 locked after reset", 2'd0, 32'h0);

        finish_run();
    end
endmodule